// File: doc/BRIEF.md
# Memory Region Attribute Matcher

This block gives every processor memory reference a set of attributes: supervisor-mode bits, cache-mode bits, a buffered-write flag and a write-protect flag. Two region registers each describe an address window. The window is an 8-bit base compared with the upper address byte, and a per-bit mask turns chosen bits of that comparison into don't-cares. When an enabled region covers the reference, its attributes are used. When no region covers it, a default attribute set is used instead. That default comes in from a separate cache control register. References that the address decoder has already mapped to on-chip Flash or SRAM skip the comparison and are flagged as bypassed.

Software writes the regions in supervisor mode through a control-register port, using a select code. The regions cannot be read back in normal operation. Reads return data only while the debug-mode input is high. Each reference is answered one clock later on registered outputs. Alongside the attributes, the outputs carry a hit flag, the index of the winning region and the bypass flag, so a consumer can tell where the attributes came from.

Top module: `mrm_top`

## Requirements
- R1: After reset both regions hold all zeros and are disabled. A debug read of either returns 0, and a reference gets the default attributes with the hit flag low.
- R2: A write with cr_wr_en and supervisor high loads cr_wdata into region 0 when cr_sel is 0x004, and into region 1 when cr_sel is 0x005. Other select codes change neither region. The stored layout is: base in bits 31:24, mask in bits 23:16, enable in bit 15, supervisor mode in bits 14:13, cache mode in bits 6:5, buffered write in bit 4 and write protect in bit 2. All other bits are stored as 0.
- R3: A write made while supervisor is low changes no region.
- R4: With cr_rd_en and debug_mode high, cr_rdata returns the stored word of the region chosen by cr_sel. In every other case, including a read while debug_mode is low, cr_rdata is 0.
- R5: A region hits when its enable bit is set and ((ref_addr_hi XOR base) AND NOT mask) is zero. On a hit, out_attr is {supervisor mode, cache mode, buffered write, write protect} of that region, out_hit is 1 and out_idx is the region number.
- R6: A set mask bit makes the matching address bit a don't-care. A cleared mask bit requires that bit to equal the base bit.
- R7: A region whose enable bit is clear never hits, whatever its base and mask.
- R8: When both regions hit, region 0 supplies the attributes and out_idx is 0.
- R9: When no region hits, out_attr equals dflt_attr and out_hit is 0.
- R10: A reference with ref_onchip high gives out_bypass 1, out_hit 0 and out_attr equal to dflt_attr, even when a region would match.
- R11: out_valid equals ref_valid from the previous clock, and the other outputs answer the reference presented in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cr_wr_en | input | 1 | Control-register write strobe |
| cr_rd_en | input | 1 | Control-register read request |
| cr_sel | input | 12 | Control-register select code |
| cr_wdata | input | 32 | Write data |
| cr_rdata | output | 32 | Read data, 0 unless a debug-mode read |
| supervisor | input | 1 | Processor is in supervisor mode |
| debug_mode | input | 1 | Debug mode active, enables reads |
| dflt_attr | input | 6 | Default attributes from cache control register |
| ref_valid | input | 1 | A reference is presented this cycle |
| ref_addr_hi | input | 8 | Reference address bits 31:24 |
| ref_onchip | input | 1 | Reference is mapped to on-chip Flash or SRAM |
| out_valid | output | 1 | Registered answer is valid |
| out_attr | output | 6 | Selected attributes |
| out_hit | output | 1 | A region supplied the attributes |
| out_idx | output | 1 | Index of the supplying region |
| out_bypass | output | 1 | Reference bypassed region matching |

## Verification
A corrupted region register does not show up on its own. It appears as wrong attributes, a wrong hit flag or a wrong index on the first reference whose upper byte falls where the stored and intended windows differ, one clock after that reference. It also appears at once on a debug read of that region. A fault in priority or in the fallback path shows only on overlapping or uncovered addresses. For that reason the directed cases place addresses inside, outside and across both windows, at masked and unmasked bit positions.

// File: rtl/mrm_pkg.sv
package mrm_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [1:0] smode;
        logic [1:0] cmode;
        logic       bufw;
        logic       wprot;
    } attr_t;

    localparam int ATTR_W = $bits(attr_t);
    localparam logic [31:0] FIELD_MASK = 32'hFFFF_E074;

    function automatic attr_t word_attr(input logic [31:0] w);
        attr_t a;
        a.smode = w[14:13];
        a.cmode = w[6:5];
        a.bufw  = w[4];
        a.wprot = w[2];
        return a;
    endfunction
endpackage

// File: rtl/mrm_region.sv
module mrm_region
    import mrm_pkg::*;
#(
    parameter int              SEL_W    = 12,
    parameter logic [SEL_W-1:0] SEL_CODE = 12'h004
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 supervisor,
    input  logic [SEL_W-1:0]     sel,
    input  logic [31:0]          wdata,
    input  logic [BYTE_W-1:0]    ref_byte,
    output logic [31:0]          word,
    output attr_t                attr,
    output logic                 hit
);
    logic [31:0]       word_q;
    logic [BYTE_W-1:0] base;
    logic [BYTE_W-1:0] mask;
    logic              en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr_en && supervisor && (sel == SEL_CODE)) begin
            word_q <= wdata & FIELD_MASK;
        end
    end

    always_comb begin
        base = word_q[31:24];
        mask = word_q[23:16];
        en   = word_q[15];
        attr = word_attr(word_q);
        hit  = en && (((ref_byte ^ base) & ~mask) == '0);
        word = word_q;
    end

    // R3: user-mode writes leave the region untouched
    p_user_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !supervisor) |=> $stable(word_q));
endmodule

// File: rtl/mrm_select.sv
module mrm_select
    import mrm_pkg::*;
#(
    parameter int NUM_REGIONS = 2,
    parameter int IDX_W       = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ref_valid,
    input  logic                   ref_onchip,
    input  logic [NUM_REGIONS-1:0] hit_vec,
    input  attr_t [NUM_REGIONS-1:0] attr_vec,
    input  attr_t                  dflt_attr,
    output logic                   out_valid,
    output attr_t                  out_attr,
    output logic                   out_hit,
    output logic [IDX_W-1:0]       out_idx,
    output logic                   out_bypass
);
    attr_t            nxt_attr;
    logic             nxt_hit;
    logic [IDX_W-1:0] nxt_idx;

    // lowest index wins: scan from highest down so the last assignment is lowest
    always_comb begin
        nxt_attr = dflt_attr;
        nxt_hit  = 1'b0;
        nxt_idx  = '0;
        if (!ref_onchip) begin
            for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
                if (hit_vec[i]) begin
                    nxt_attr = attr_vec[i];
                    nxt_hit  = 1'b1;
                    nxt_idx  = IDX_W'(i);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_attr   <= '0;
            out_hit    <= 1'b0;
            out_idx    <= '0;
            out_bypass <= 1'b0;
        end else begin
            out_valid  <= ref_valid;
            out_attr   <= nxt_attr;
            out_hit    <= nxt_hit;
            out_idx    <= nxt_idx;
            out_bypass <= ref_onchip;
        end
    end

    // R11: answer appears exactly one cycle after the reference
    p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> out_valid);
    // R10: bypassed references never report a hit
    p_bypass_no_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_bypass) |-> !out_hit);
    // R8: region 0 wins whenever it hits
    p_region0_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && !ref_onchip && hit_vec[0]) |=> (out_hit && out_idx == '0));
    // R9: no hit falls back to the default set
    p_default_on_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && !ref_onchip && hit_vec == '0) |=> (!out_hit && out_attr == $past(dflt_attr)));
endmodule

// File: rtl/mrm_top.sv
module mrm_top
    import mrm_pkg::*;
#(
    parameter int              NUM_REGIONS = 2,
    parameter int              SEL_W       = 12,
    parameter logic [SEL_W-1:0] SEL_BASE    = 12'h004,
    localparam int             IDX_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cr_wr_en,
    input  logic               cr_rd_en,
    input  logic [SEL_W-1:0]   cr_sel,
    input  logic [31:0]        cr_wdata,
    output logic [31:0]        cr_rdata,
    input  logic               supervisor,
    input  logic               debug_mode,
    input  logic [5:0]         dflt_attr,
    input  logic               ref_valid,
    input  logic [7:0]         ref_addr_hi,
    input  logic               ref_onchip,
    output logic               out_valid,
    output logic [5:0]         out_attr,
    output logic               out_hit,
    output logic [IDX_W-1:0]   out_idx,
    output logic               out_bypass
);
    logic [NUM_REGIONS-1:0]        hit_vec;
    attr_t [NUM_REGIONS-1:0]       attr_vec;
    logic [NUM_REGIONS-1:0][31:0]  word_vec;
    attr_t                         sel_attr;

    for (genvar gi = 0; gi < NUM_REGIONS; gi++) begin : g_region
        mrm_region #(
            .SEL_W    (SEL_W),
            .SEL_CODE (SEL_BASE + SEL_W'(gi))
        ) u_region (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (cr_wr_en),
            .supervisor (supervisor),
            .sel        (cr_sel),
            .wdata      (cr_wdata),
            .ref_byte   (ref_addr_hi),
            .word       (word_vec[gi]),
            .attr       (attr_vec[gi]),
            .hit        (hit_vec[gi])
        );
    end

    always_comb begin
        cr_rdata = '0;
        if (cr_rd_en && debug_mode) begin
            for (int i = 0; i < NUM_REGIONS; i++) begin
                if (cr_sel == SEL_BASE + SEL_W'(i)) cr_rdata = word_vec[i];
            end
        end
    end

    mrm_select #(
        .NUM_REGIONS (NUM_REGIONS),
        .IDX_W       (IDX_W)
    ) u_select (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_valid  (ref_valid),
        .ref_onchip (ref_onchip),
        .hit_vec    (hit_vec),
        .attr_vec   (attr_vec),
        .dflt_attr  (attr_t'(dflt_attr)),
        .out_valid  (out_valid),
        .out_attr   (sel_attr),
        .out_hit    (out_hit),
        .out_idx    (out_idx),
        .out_bypass (out_bypass)
    );

    assign out_attr = sel_attr;

    // R4: nothing leaves the read port outside debug mode
    p_no_read_outside_debug_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !debug_mode |-> (cr_rdata == '0));
endmodule

// File: tb/mrm_top_bench.sv
module mrm_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cr_wr_en = 1'b0, cr_rd_en = 1'b0;
    logic [11:0] cr_sel = '0;
    logic [31:0] cr_wdata = '0, cr_rdata;
    logic        supervisor = 1'b0, debug_mode = 1'b0;
    logic [5:0]  dflt_attr = 6'b10_11_0_1;
    logic        ref_valid = 1'b0, ref_onchip = 1'b0;
    logic [7:0]  ref_addr_hi = '0;
    logic        out_valid, out_hit, out_bypass;
    logic [0:0]  out_idx;
    logic [5:0]  out_attr;
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    mrm_top u_mrm_top (
        .clk(clk), .rst_n(rst_n), .cr_wr_en(cr_wr_en), .cr_rd_en(cr_rd_en),
        .cr_sel(cr_sel), .cr_wdata(cr_wdata), .cr_rdata(cr_rdata),
        .supervisor(supervisor), .debug_mode(debug_mode), .dflt_attr(dflt_attr),
        .ref_valid(ref_valid), .ref_addr_hi(ref_addr_hi), .ref_onchip(ref_onchip),
        .out_valid(out_valid), .out_attr(out_attr), .out_hit(out_hit),
        .out_idx(out_idx), .out_bypass(out_bypass)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkreg(input logic [7:0] base, input logic [7:0] mask,
            input logic en, input logic [5:0] a);
        return {base, mask, en, a[5:4], 6'b0, a[3:2], a[1], 1'b0, a[0], 2'b0};
    endfunction

    task automatic wr(input logic [11:0] sel, input logic [31:0] d, input logic sup);
        @(negedge clk);
        cr_wr_en = 1'b1; cr_sel = sel; cr_wdata = d; supervisor = sup;
        @(negedge clk);
        cr_wr_en = 1'b0; supervisor = 1'b0;
    endtask

    task automatic rd(input logic [11:0] sel, input logic dbg, output logic [31:0] d);
        @(negedge clk);
        cr_rd_en = 1'b1; cr_sel = sel; debug_mode = dbg;
        #1 d = cr_rdata;
        cr_rd_en = 1'b0; debug_mode = 1'b0;
    endtask

    // answer sampled at the negedge after the capturing posedge
    task automatic ref_chk(input string req, input logic [7:0] a, input logic onchip,
            input logic [5:0] e_attr, input logic e_hit, input logic e_idx);
        @(negedge clk);
        ref_valid = 1'b1; ref_addr_hi = a; ref_onchip = onchip;
        @(negedge clk);
        ref_valid = 1'b0; ref_onchip = 1'b0;
        chk({req, " valid"}, 32'(out_valid), 32'd1);
        chk({req, " attr"}, 32'(out_attr), 32'(e_attr));
        chk({req, " hit"}, 32'(out_hit), 32'(e_hit));
        if (e_hit) chk({req, " idx"}, 32'(out_idx), 32'(e_idx));
        chk({req, " bypass"}, 32'(out_bypass), 32'(onchip));
    endtask

    localparam logic [5:0] A0 = 6'b10_01_1_0;
    localparam logic [5:0] A1 = 6'b01_10_0_1;

    task automatic t_reset();
        logic [31:0] d;
        rd(12'h004, 1'b1, d); chk("R1 region0 cleared", d, 0);
        rd(12'h005, 1'b1, d); chk("R1 region1 cleared", d, 0);
        ref_chk("R1 reset default", 8'h00, 1'b0, dflt_attr, 1'b0, 1'b0);
    endtask

    task automatic t_write_read();
        logic [31:0] d;
        wr(12'h004, mkreg(8'h40, 8'h00, 1'b1, A0) | 32'h0000_1F8B, 1'b1);
        rd(12'h004, 1'b1, d); chk("R2 layout readback", d, mkreg(8'h40, 8'h00, 1'b1, A0));
        rd(12'h004, 1'b0, d); chk("R4 no read outside debug", d, 0);
        wr(12'h006, 32'hFFFF_FFFF, 1'b1);
        rd(12'h004, 1'b1, d); chk("R2 bad sel region0", d, mkreg(8'h40, 8'h00, 1'b1, A0));
        rd(12'h005, 1'b1, d); chk("R2 bad sel region1", d, 0);
    endtask

    task automatic t_user_write();
        logic [31:0] d;
        wr(12'h005, 32'hFFFF_FFFF, 1'b0);
        rd(12'h005, 1'b1, d); chk("R3 user write ignored", d, 0);
        ref_chk("R3 user write no hit", 8'hC3, 1'b0, dflt_attr, 1'b0, 1'b0);
    endtask

    task automatic t_match();
        ref_chk("R5 exact hit", 8'h40, 1'b0, A0, 1'b1, 1'b0);
        ref_chk("R9 miss default", 8'h41, 1'b0, dflt_attr, 1'b0, 1'b0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(12'h005, mkreg(8'h80, 8'h0F, 1'b1, A1), 1'b1);
        rd(12'h005, 1'b1, d); chk("R2 region1 write", d, mkreg(8'h80, 8'h0F, 1'b1, A1));
        ref_chk("R6 masked bits dont care", 8'h8A, 1'b0, A1, 1'b1, 1'b1);
        ref_chk("R6 unmasked bit differs", 8'h90, 1'b0, dflt_attr, 1'b0, 1'b0);
    endtask

    task automatic t_overlap();
        wr(12'h004, mkreg(8'h80, 8'hFF, 1'b1, A0), 1'b1);
        ref_chk("R8 overlap region0 wins", 8'h8A, 1'b0, A0, 1'b1, 1'b0);
        ref_chk("R6 full mask matches any", 8'h13, 1'b0, A0, 1'b1, 1'b0);
    endtask

    task automatic t_disable();
        wr(12'h004, mkreg(8'h8A, 8'hFF, 1'b0, A0), 1'b1);
        ref_chk("R7 disabled region skipped", 8'h8A, 1'b0, A1, 1'b1, 1'b1);
        ref_chk("R7 disabled gives miss", 8'h40, 1'b0, dflt_attr, 1'b0, 1'b0);
    endtask

    task automatic t_bypass();
        ref_chk("R10 onchip bypass", 8'h85, 1'b1, dflt_attr, 1'b0, 1'b0);
        dflt_attr = 6'b00_01_1_1;
        ref_chk("R9 new default", 8'h20, 1'b0, 6'b00_01_1_1, 1'b0, 1'b0);
    endtask

    task automatic t_valid();
        @(negedge clk);
        ref_valid = 1'b0; ref_addr_hi = 8'h85;
        @(negedge clk);
        chk("R11 idle no valid", 32'(out_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset out_valid", 32'(out_valid), 32'd0);
        t_reset();
        t_write_read();
        t_user_write();
        t_match();
        t_mask();
        t_overlap();
        t_disable();
        t_bypass();
        t_valid();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule